// File: doc/BRIEF.md
# Soft-Decision Branch Metric Unit

This block produces the branch metrics that drive one trellis step of a soft-decision convolutional decoder for codes of rate 1/2, 1/3 and 1/4. Each step, a group of up to four signed soft symbols arrives together with a rate selector. For every butterfly of the trellis, the block correlates that symbol group with the encoder output that the butterfly expects, and returns one signed metric per butterfly. The symbol group is shared by every butterfly of the step.

The expected encoder outputs are not fed in. They come from a constant table that is built at elaboration from the constraint length and the generator polynomials given as parameters. A 16-state code (constraint length 5) yields 8 metrics per step and a 64-state code (constraint length 7, the default) yields 32. Path metric update and traceback sit downstream and take the metric vector through a valid/ready handshake. Every accepted symbol group produces exactly one output beat.

Top module: `soft_bmu_top`

## Requirements
- R1: During and directly after reset, `out_valid` is 0, `out_metric` is all zeros, and `in_ready` is 1 even when `out_ready` is 0.
- R2: For butterfly index b and symbol slot j, the flip bit is the XOR reduction of (b zero-extended to the constraint length) AND polynomial j. The polynomials are packed with slot 0 in the lowest bits. An enabled slot contributes the soft symbol unchanged when its flip bit is 0 and negated when it is 1. Metric b is placed at `out_metric[b*16 +: 16]`.
- R3: Negating the most negative symbol value -32768 yields +32767.
- R4: Rate code 2'b00 (rate 1/2): the metric is the saturated sum of the slot 0 and slot 1 terms. Symbols in slots 2 and 3 have no effect on any metric.
- R5: Rate code 2'b01 (rate 1/3): the metric is sat(sat(t0+t1) + t2). The symbol in slot 3 has no effect.
- R6: Rate codes 2'b10 and 2'b11 (rate 1/4): the metric is sat(sat(t0+t1) + sat(t2+t3)).
- R7: Every addition in the tree saturates separately to the range [-32768, +32767]. An overflow in the first level is clamped before the second level adds to it.
- R8: A group accepted at a rising edge (`in_valid` and `in_ready` both high) is presented on `out_valid` after the second rising edge that follows, provided the pipeline does not stall. Groups can be accepted back to back, one per cycle, and they leave in order.
- R9: While `out_valid` is high and `out_ready` is low, `out_metric` holds steady and `in_ready` is low. A group offered during a stall is taken afterwards, not lost and not duplicated. Every output beat corresponds to exactly one accepted group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Symbol group present |
| in_ready | output | 1 | Block can take a symbol group |
| in_rate | input | 2 | Rate code: 00 = 1/2, 01 = 1/3, 10 or 11 = 1/4 |
| in_sym | input | 64 | Four signed 16-bit soft symbols, slot j at bits [16j+15:16j] |
| out_valid | output | 1 | Metric vector present |
| out_ready | input | 1 | Downstream takes the metric vector |
| out_metric | output | 512 | One signed 16-bit metric per butterfly, butterfly b at bits [16b+15:16b] |

## Verification
A group that is accepted on a rising edge shows up on the output after two more registers: the prepared-term register and the metric register. The bench drives inputs on falling edges. At the first falling edge after acceptance it checks that `out_valid` is still low. At the second falling edge it checks `out_valid` high and compares every butterfly against a model built from the requirements. In the stall test, `out_ready` is held low and the bench checks the held vector, and the low `in_ready`, at each falling edge. After release it expects the queued groups on consecutive falling edges. In the streaming test it expects the groups on consecutive falling edges, one per cycle.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    // Soft symbol and metric width
    localparam int unsigned SOFT_W     = 16;
    // Symbol slots per group (rate 1/4 uses all of them)
    localparam int unsigned MAX_SYMS   = 4;
    // Pairs summed in the first level of the tree
    localparam int unsigned TREE_PAIRS = MAX_SYMS / 2;

    typedef logic signed [SOFT_W-1:0] soft_t;

    localparam soft_t SOFT_MAX = soft_t'({1'b0, {(SOFT_W-1){1'b1}}});
    localparam soft_t SOFT_MIN = soft_t'({1'b1, {(SOFT_W-1){1'b0}}});

    typedef enum logic [1:0] {
        RATE_HALF     = 2'b00,
        RATE_THIRD    = 2'b01,
        RATE_QUARTER  = 2'b10,
        RATE_QUARTER2 = 2'b11
    } rate_e;

    // Both possible contributions of one symbol slot
    typedef struct packed {
        soft_t pos;
        soft_t neg;
    } term_pair_t;

    typedef term_pair_t [MAX_SYMS-1:0] pair_vec_t;

    // Signed add, clamped to the soft range
    function automatic soft_t sat_add(soft_t a, soft_t b);
        logic [SOFT_W:0] wide;
        wide = {a[SOFT_W-1], a} + {b[SOFT_W-1], b};
        if (wide[SOFT_W] != wide[SOFT_W-1])
            return wide[SOFT_W] ? SOFT_MIN : SOFT_MAX;
        return soft_t'(wide[SOFT_W-1:0]);
    endfunction

    // Negation that maps the most negative value to the most positive
    function automatic soft_t sat_neg(soft_t a);
        if (a == SOFT_MIN)
            return SOFT_MAX;
        return soft_t'(-a);
    endfunction

    function automatic int unsigned active_syms(rate_e r);
        case (r)
            RATE_HALF:  return 2;
            RATE_THIRD: return 3;
            default:    return MAX_SYMS;
        endcase
    endfunction

    function automatic logic sym_enabled(rate_e r, int unsigned slot);
        return slot < active_syms(r);
    endfunction

endpackage

// File: rtl/bmu_term_prep.sv
// Builds the positive and negated term of every symbol slot once per group.
// Slots beyond the selected rate are forced to zero in both forms.
module bmu_term_prep
    import bmu_pkg::*;
(
    input  logic [MAX_SYMS*SOFT_W-1:0] sym_flat,
    input  rate_e                      rate,
    output pair_vec_t                  pairs
);

    for (genvar j = 0; j < MAX_SYMS; j++) begin : g_slot
        soft_t      sym;
        logic       en;
        term_pair_t pr;

        assign sym    = soft_t'(sym_flat[j*SOFT_W +: SOFT_W]);
        assign en     = sym_enabled(rate, j);
        assign pr.pos = en ? sym : '0;
        assign pr.neg = en ? sat_neg(sym) : '0;
        assign pairs[j] = pr;
    end

endmodule

// File: rtl/bmu_code_table.sv
// Constant table of expected-output flip bits, one row per butterfly.
// A flip bit of 1 means the expected antipodal output is negative.
module bmu_code_table
    import bmu_pkg::*;
#(
    parameter int unsigned CONSTR_LEN = 7,
    parameter logic [MAX_SYMS-1:0][CONSTR_LEN-1:0] POLYS = '0,
    localparam int unsigned NUM_BFLY = 1 << (CONSTR_LEN - 2)
) (
    output logic [NUM_BFLY-1:0][MAX_SYMS-1:0] flip
);

    for (genvar b = 0; b < NUM_BFLY; b++) begin : g_row
        localparam logic [CONSTR_LEN-1:0] IDX = CONSTR_LEN'(b);
        for (genvar j = 0; j < MAX_SYMS; j++) begin : g_col
            assign flip[b][j] = ^(IDX & POLYS[j]);
        end
    end

endmodule

// File: rtl/bmu_bfly.sv
// One butterfly: pick each term by its flip bit, then add them in a
// two-level tree that saturates at every level.
module bmu_bfly
    import bmu_pkg::*;
(
    input  pair_vec_t           pairs,
    input  logic [MAX_SYMS-1:0] flip,
    output soft_t               metric
);

    soft_t term [MAX_SYMS];
    soft_t part [TREE_PAIRS];

    for (genvar j = 0; j < MAX_SYMS; j++) begin : g_term
        assign term[j] = flip[j] ? pairs[j].neg : pairs[j].pos;
    end

    for (genvar p = 0; p < TREE_PAIRS; p++) begin : g_lvl0
        assign part[p] = sat_add(term[2*p], term[2*p+1]);
    end

    assign metric = sat_add(part[0], part[1]);

endmodule

// File: rtl/soft_bmu_top.sv
module soft_bmu_top
    import bmu_pkg::*;
#(
    parameter int unsigned CONSTR_LEN = 7,
    parameter logic [MAX_SYMS-1:0][CONSTR_LEN-1:0] POLYS =
        {7'h4F, 7'h65, 7'h79, 7'h5B}
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   in_valid,
    output logic                                   in_ready,
    input  logic [1:0]                             in_rate,
    input  logic [MAX_SYMS*SOFT_W-1:0]             in_sym,
    output logic                                   out_valid,
    input  logic                                   out_ready,
    output logic [(SOFT_W<<(CONSTR_LEN-2))-1:0]    out_metric
);

    localparam int unsigned NUM_BFLY = 1 << (CONSTR_LEN - 2);
    localparam int unsigned MET_W    = NUM_BFLY * SOFT_W;

    logic                             advance;
    pair_vec_t                        prep_pairs;
    pair_vec_t                        s1_pairs;
    logic                             s1_valid;
    logic [NUM_BFLY-1:0][MAX_SYMS-1:0] flip_tab;
    logic [NUM_BFLY-1:0][SOFT_W-1:0]   metric_vec;

    // Whole pipeline moves together unless the output is held
    assign advance  = !out_valid || out_ready;
    assign in_ready = advance;

    bmu_term_prep u_prep (
        .sym_flat (in_sym),
        .rate     (rate_e'(in_rate)),
        .pairs    (prep_pairs)
    );

    bmu_code_table #(
        .CONSTR_LEN (CONSTR_LEN),
        .POLYS      (POLYS)
    ) u_table (
        .flip (flip_tab)
    );

    for (genvar b = 0; b < NUM_BFLY; b++) begin : g_bfly
        soft_t m;
        bmu_bfly u_bfly (
            .pairs  (s1_pairs),
            .flip   (flip_tab[b]),
            .metric (m)
        );
        assign metric_vec[b] = m;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid   <= 1'b0;
            s1_pairs   <= '0;
            out_valid  <= 1'b0;
            out_metric <= '0;
        end else if (advance) begin
            s1_valid  <= in_valid;
            if (in_valid)
                s1_pairs <= prep_pairs;
            out_valid <= s1_valid;
            if (s1_valid)
                out_metric <= MET_W'(metric_vec);
        end
    end

endmodule

// File: rtl/bmu_chk.sv
module bmu_chk #(
    parameter int unsigned MET_W = 512
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [MET_W-1:0] out_metric
);

    logic       acc;
    logic       emit;
    logic [1:0] inflight;
    logic       rst_q;

    assign acc  = in_valid && in_ready;
    assign emit = out_valid && out_ready;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)
            inflight <= '0;
        else
            inflight <= inflight + 2'(acc) - 2'(emit);
        // R1
        if (rst_q)
            reset_idle_chk: assert (!out_valid);
    end

    // R8
    inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
        inflight <= 2'd2);

    // R9
    emit_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> inflight != 2'd0);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_metric)));

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) ##1 in_ready |=> out_valid);

endmodule

bind soft_bmu_top bmu_chk #(.MET_W(MET_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_metric (out_metric)
);

// File: tb/soft_bmu_top_tb_top.sv
module soft_bmu_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 32;
    localparam logic [3:0][6:0] TB_POLYS = {7'h4F, 7'h65, 7'h79, 7'h5B};

    typedef struct packed {
        logic [1:0]         rate;
        logic signed [15:0] s0;
        logic signed [15:0] s1;
        logic signed [15:0] s2;
        logic signed [15:0] s3;
        logic signed [15:0] e0;   // butterfly 0: all terms positive
        logic signed [15:0] e1;   // butterfly 1: all terms negated
    } vec_t;

    // Stimulus with expected metrics of butterflies 0 and 1
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'sd100,    16'sd200,    16'sd999,     -16'sd999,   16'sd300,    -16'sd300},   // R4
        '{2'd1, 16'sd100,    -16'sd50,    16'sd25,      16'sd7777,   16'sd75,     -16'sd75},    // R5
        '{2'd2, 16'sd1000,   16'sd2000,   16'sd3000,    16'sd4000,   16'sd10000,  -16'sd10000}, // R6
        '{2'd3, -16'sd5,     -16'sd6,     -16'sd7,      -16'sd8,     -16'sd26,    16'sd26},     // R6
        '{2'd2, 16'sd30000,  16'sd30000,  -16'sd100,    16'sd0,      16'sd32667,  -16'sd32668}, // R7
        '{2'd2, -16'sd30000, -16'sd30000, -16'sd30000,  -16'sd30000, 16'sh8000,   16'sd32767},  // R7
        '{2'd0, 16'sh8000,   16'sd0,      16'sd0,       16'sd0,      16'sh8000,   16'sd32767},  // R3
        '{2'd1, 16'sd20000,  16'sd20000,  -16'sd20000,  16'sd5,      16'sd12767,  -16'sd12768}, // R7
        '{2'd2, 16'sd0,      16'sd0,      16'sd0,       16'sd0,      16'sd0,      16'sd0}
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic            in_ready;
    logic [1:0]      in_rate;
    logic [63:0]     in_sym;
    logic            out_valid;
    logic            out_ready;
    logic [NB*16-1:0] out_metric;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    soft_bmu_top #(
        .CONSTR_LEN (7),
        .POLYS      (TB_POLYS)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_rate    (in_rate),
        .in_sym     (in_sym),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_metric (out_metric)
    );

    function automatic int clamp16(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Requirement-level model of one metric
    function automatic int model(logic [1:0] rate, logic [63:0] syms, int b);
        int nact;
        int t [4];
        nact = (rate == 2'd0) ? 2 : (rate == 2'd1) ? 3 : 4;
        for (int j = 0; j < 4; j++) begin
            int   s;
            logic f;
            s = int'($signed(syms[j*16 +: 16]));
            f = ^(7'(b) & TB_POLYS[j]);
            if (j >= nact)
                t[j] = 0;
            else
                t[j] = f ? clamp16(-s) : s;
        end
        return clamp16(clamp16(t[0] + t[1]) + clamp16(t[2] + t[3]));
    endfunction

    function automatic int got_metric(int b);
        return int'($signed(out_metric[b*16 +: 16]));
    endfunction

    function automatic string rate_tag(logic [1:0] rate);
        if (rate == 2'd0) return "R4";
        if (rate == 2'd1) return "R5";
        return "R6";
    endfunction

    task automatic chk(string tag, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Compare all butterflies against the model (R2)
    task automatic chk_all(vec_t v);
        logic [63:0] syms;
        int bad;
        int first;
        syms  = {v.s3, v.s2, v.s1, v.s0};
        bad   = 0;
        first = -1;
        for (int b = 0; b < NB; b++) begin
            if (got_metric(b) != model(v.rate, syms, b)) begin
                bad++;
                if (first < 0) first = b;
            end
        end
        n_checks++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL R2: butterfly %0d got %0d expected %0d", first,
                     got_metric(first), model(v.rate, syms, first));
        end
    endtask

    task automatic drive(vec_t v);
        in_rate  = v.rate;
        in_sym   = {v.s3, v.s2, v.s1, v.s0};
        in_valid = 1'b1;
    endtask

    task automatic run_vec(vec_t v);
        @(negedge clk);
        drive(v);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8", int'(out_valid), 0);
        @(negedge clk);
        chk("R8", int'(out_valid), 1);
        chk(rate_tag(v.rate), got_metric(0), int'(v.e0));
        chk("R2", got_metric(1), int'(v.e1));
        chk_all(v);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_rate   = 2'd0;
        in_sym    = '0;
        out_ready = 1'b0;

        // Reset state (R1)
        repeat (3) @(negedge clk);
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(in_ready), 1);
        chk("R1", int'(out_metric != '0), 0);
        rst       = 1'b0;
        out_ready = 1'b1;

        // Vector table: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++)
            run_vec(VECS[i]);

        // Back-pressure (R9): A and B queued, C offered during the stall
        @(negedge clk);
        out_ready = 1'b0;
        drive(VECS[2]);
        @(posedge clk);
        @(negedge clk);
        chk("R9", int'(in_ready), 1);
        drive(VECS[4]);
        @(posedge clk);
        @(negedge clk);
        drive(VECS[7]);
        for (int k = 0; k < 3; k++) begin
            chk("R9", int'(out_valid), 1);
            chk("R9", int'(in_ready), 0);
            chk("R9", got_metric(0), int'(VECS[2].e0));
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9", int'(out_valid), 1);
        chk("R9", got_metric(0), int'(VECS[4].e0));
        chk_all(VECS[4]);
        @(negedge clk);
        chk("R9", int'(out_valid), 1);
        chk("R9", got_metric(0), int'(VECS[7].e0));
        chk_all(VECS[7]);
        @(negedge clk);
        chk("R9", int'(out_valid), 0);

        // Back-to-back stream, one group per cycle (R8)
        @(negedge clk);
        drive(VECS[2]);
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 0) drive(VECS[4]);
            if (k == 1) drive(VECS[7]);
            if (k == 2) in_valid = 1'b0;
            if (k == 0 || k == 4) begin
                chk("R8", int'(out_valid), 0);
            end else begin
                chk("R8", int'(out_valid), 1);
                chk("R8", got_metric(1),
                    int'((k == 1) ? VECS[2].e1 : (k == 2) ? VECS[4].e1 : VECS[7].e1));
            end
        end

        finish_run();
    end

endmodule